// File: doc/BRIEF.md
# Module Block Framer with CRC-8

The framer turns a burst of payload words into a self-describing module block on a 32-bit output stream. When a burst starts, it captures the event number and emits a header word. It then forwards every payload word unchanged. After the last payload word it appends a trailer word. The trailer holds a CRC-8 over the header and the payload, four active-low error flags and the number of payload words.

The input is a valid/last stream that receives ready from the framer. The output is a valid/ready stream whose word stays frozen while the consumer stalls. Payload words must have bit 31 clear, so that their type code is in the range 0 to 7. A burst carries at least one payload word.

Top module: `mbf_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` and `inReady` are low.
- R2: The first word of every block is the header: bits 31:28 = 4'b1000, bits 27:0 = `eventNum` as seen in the idle cycle where `inValid` first appears. No payload word is accepted while the header is offered.
- R3: Payload words appear on `outData` unchanged and in order. An input word is accepted only in a cycle where the output is also accepted (`inReady` implies `outReady`).
- R4: The trailer follows the last payload word, with bits 31:28 = 4'b1001 and bits 15:0 = the number of payload words (header and trailer excluded).
- R5: Trailer bits 27:20 hold a CRC-8 with polynomial 0xD5, initial value 0 and no final XOR. Each 32-bit word is fed byte 0 (bits 7:0) first, each byte most-significant bit first. The CRC covers the header and every payload word, and changes only on accepted transfers.
- R6: Trailer bits 19, 18, 17 and 16 carry `accErrN`, `ttcErrN`, `rdErrN` and `ovfErrN`, where 1 means no error. Their values are sampled on the transfer of the last payload word. Changes at any other time have no effect.
- R7: The count saturates at 65535. A block of more than 65535 payload words forces trailer bit 16 to 0. A block of exactly 65535 words reports 65535 and passes `ovfErrN` through.
- R8: While `outValid` is high and `outReady` is low, the next cycle keeps `outValid` high and `outData` unchanged.
- R9: After a trailer is accepted, `outValid` is low for at least one cycle before the next block's header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload word available |
| inReady | output | 1 | Payload word taken this cycle |
| inData | input | 32 | Payload word, bit 31 clear |
| inLast | input | 1 | Marks the final payload word of a burst |
| eventNum | input | 28 | Event number placed in the header |
| accErrN | input | 1 | Access error, active low |
| ttcErrN | input | 1 | Timing/trigger error, active low |
| rdErrN | input | 1 | Readout error, active low |
| ovfErrN | input | 1 | Readout overflow, active low |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Consumer accepts output word |
| outData | output | 32 | Framed output word |

## Verification
A CRC register that advances on a stalled cycle, or that misses a byte, shows up only in bits 27:20 of the trailer. That happens one word after the last payload transfer, so a whole block passes before the fault is visible. The bench therefore checks every trailer against a CRC computed in the bench, under random backpressure and input gaps. A wrong sequencer state shows sooner: a missing header, a word lost or repeated, or a missing bubble breaks the compared word order at the very next accepted transfer. Faults in the count or the saturation flag appear only at the block boundary. The bench reaches that boundary with bursts of exactly 65535 and 65536 words.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 4;
  localparam int EVT_W  = WORD_W - TYPE_W;
  localparam int CNT_W  = 16;
  localparam int CRC_W  = 8;
  localparam int FLAG_W = 4;
  localparam int BYTES  = WORD_W / 8;
  localparam logic [CRC_W-1:0]  CRC_POLY = 8'hD5;
  localparam logic [TYPE_W-1:0] TYPE_HDR = 4'b1000;
  localparam logic [TYPE_W-1:0] TYPE_TRL = 4'b1001;
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

  typedef enum logic [1:0] {SEL_HDR, SEL_PAY, SEL_TRL} selT;

  typedef struct packed {
    logic loadHdr;    // capture event number, clear crc and count
    logic accHdr;     // header accepted: fold it into crc
    logic accWord;    // payload accepted: fold into crc, bump count
    logic latchFlags; // last payload accepted: sample error flags
    selT  sel;        // output word source
  } strobeT;

  function automatic logic [CRC_W-1:0] crcWord(logic [CRC_W-1:0] c, logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < BYTES; b++) begin
      r = r ^ w[8*b +: 8];
      for (int k = 0; k < 8; k++)
        r = r[CRC_W-1] ? ({r[CRC_W-2:0], 1'b0} ^ CRC_POLY) : {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/mbf_ctrl.sv
module mbf_ctrl
  import mbf_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   outReady,
  output logic   inReady,
  output logic   outValid,
  output strobeT strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_TRL} stateT;
  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    inReady   = 1'b0;
    outValid  = 1'b0;
    strobe    = '{loadHdr: 1'b0, accHdr: 1'b0, accWord: 1'b0, latchFlags: 1'b0, sel: SEL_HDR};
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          strobe.loadHdr = 1'b1;
          stateNext      = ST_HDR;
        end
      end
      ST_HDR: begin
        outValid   = 1'b1;
        strobe.sel = SEL_HDR;
        if (outReady) begin
          strobe.accHdr = 1'b1;
          stateNext     = ST_PAY;
        end
      end
      ST_PAY: begin
        outValid   = inValid;
        inReady    = outReady;
        strobe.sel = SEL_PAY;
        if (inValid && outReady) begin
          strobe.accWord = 1'b1;
          if (inLast) begin
            strobe.latchFlags = 1'b1;
            stateNext         = ST_TRL;
          end
        end
      end
      ST_TRL: begin
        outValid   = 1'b1;
        strobe.sel = SEL_TRL;
        if (outReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/mbf_dpath.sv
module mbf_dpath
  import mbf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [EVT_W-1:0]  eventNum,
  input  logic [WORD_W-1:0] inData,
  input  logic [FLAG_W-1:0] flagsN,
  output logic [WORD_W-1:0] outData
);
  logic [EVT_W-1:0]  evtQ;
  logic [CRC_W-1:0]  crcQ;
  logic [CNT_W-1:0]  cntQ;
  logic              satQ;
  logic [FLAG_W-1:0] flagQ;
  logic [WORD_W-1:0] hdrWord, trlWord, crcIn;

  assign hdrWord = {TYPE_HDR, evtQ};
  assign trlWord = {TYPE_TRL, crcQ, flagQ[3:1], flagQ[0] & ~satQ, cntQ};
  assign crcIn   = (strobe.sel == SEL_HDR) ? hdrWord : inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtQ  <= '0;
      crcQ  <= '0;
      cntQ  <= '0;
      satQ  <= 1'b0;
      flagQ <= '1;
    end else begin
      if (strobe.loadHdr) begin
        evtQ <= eventNum;
        crcQ <= '0;
        cntQ <= '0;
        satQ <= 1'b0;
      end
      if (strobe.accHdr || strobe.accWord) crcQ <= crcWord(crcQ, crcIn);
      if (strobe.accWord) begin
        if (cntQ == CNT_MAX) satQ <= 1'b1;
        else                 cntQ <= cntQ + 1'b1;
      end
      if (strobe.latchFlags) flagQ <= flagsN;
    end
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_HDR: outData = hdrWord;
      SEL_PAY: outData = inData;
      default: outData = trlWord;
    endcase
  end
endmodule

// File: rtl/mbf_framer.sv
module mbf_framer
  import mbf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  input  logic [EVT_W-1:0]  eventNum,
  input  logic              accErrN,
  input  logic              ttcErrN,
  input  logic              rdErrN,
  input  logic              ovfErrN,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData
);
  strobeT strobe;

  mbf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  mbf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eventNum(eventNum), .inData(inData),
    .flagsN({accErrN, ttcErrN, rdErrN, ovfErrN}), .outData(outData)
  );
endmodule

// File: rtl/mbf_framer_chk.sv
module mbf_framer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] inData,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  a_r3_pass: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |-> outValid && outData == inData);

  a_r3_ready: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> outReady);

  a_r9_bubble: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outData[31:28] == 4'b1001 |=> !outValid);

  a_r2_hdr_noacc: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outData[31:28] == 4'b1000 |-> !inReady);
endmodule

bind mbf_framer mbf_framer_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
  .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/mbf_framer_bench.sv
module mbf_framer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, outReady = 1'b1;
  logic        inReady, outValid;
  logic [31:0] inData = '0, outData;
  logic [27:0] eventNum = '0;
  logic [3:0]  flg = 4'hF;
  logic        stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] expQ[$];
  string       tagQ[$];
  int          total = 0, bad = 0, cycles = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  mbf_framer u_mbf_framer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .eventNum(eventNum), .accErrN(flg[3]), .ttcErrN(flg[2]),
    .rdErrN(flg[1]), .ovfErrN(flg[0]), .outValid(outValid), .outReady(outReady),
    .outData(outData)
  );

  function automatic logic [7:0] refCrc(logic [7:0] c, logic [31:0] w);
    logic fb;
    for (int b = 0; b < 4; b++)
      for (int k = 7; k >= 0; k--) begin
        fb = c[7] ^ w[8*b + k];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'hD5 : 8'h00);
      end
    return c;
  endfunction

  function automatic logic [31:0] wordAt(logic [31:0] seed, int i);
    return (seed + i * 32'h9E3779B1) & 32'h7FFF_FFFF;
  endfunction

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // ready generator
  always @(posedge clk) begin
    #1;
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady <= stall ? lfsr[0] | lfsr[3] : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) check(outData, 32'hxxxx_xxxx, "R9 unexpected word");
      else check(outData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 195000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog got=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic sendBlock(logic [27:0] evt, int n, logic [31:0] seed, logic [3:0] f,
                           bit gap, bit stl);
    logic [7:0]  c;
    logic [31:0] hdr;
    int          cnt;
    logic        ovf;
    hdr = {4'b1000, evt};
    expQ.push_back(hdr); tagQ.push_back("R2 header");
    c = refCrc(8'h00, hdr);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(wordAt(seed, i)); tagQ.push_back("R3 payload");
      c = refCrc(c, wordAt(seed, i));
    end
    cnt = (n > 65535) ? 65535 : n;
    ovf = (n > 65535) ? 1'b0 : f[0];
    expQ.push_back({4'b1001, c, f[3:1], ovf, cnt[15:0]});
    tagQ.push_back("R4 R5 R6 R7 trailer");
    stall    = stl;
    eventNum = evt;
    for (int i = 0; i < n; i++) begin
      inData  = wordAt(seed, i);
      inLast  = (i == n - 1);
      inValid = 1'b1;
      flg     = (i == n - 1 || i == 0) ? f : ~f;
      do @(negedge clk); while (!inReady);
      @(posedge clk); #1;
      if (i == 0) eventNum = ~evt;
      if (gap) begin
        inValid = 1'b0;
        @(posedge clk); #1;
      end
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    flg     = ~f;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({31'd0, outValid}, 32'd0, "R1 outValid in reset");
    check({31'd0, inReady},  32'd0, "R1 inReady in reset");
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check({31'd0, outValid}, 32'd0, "R1 outValid after reset");
    check({31'd0, inReady},  32'd0, "R1 inReady after reset");
    @(posedge clk); #1;

    sendBlock(28'h0000123, 1, 32'h11, 4'hF, 1'b0, 1'b0);
    sendBlock(28'hABCDEF1, 5, 32'h2222, 4'b0101, 1'b1, 1'b1);
    sendBlock(28'h5A5A5A5, 3, 32'h333, 4'b1010, 1'b0, 1'b1);
    sendBlock(28'hFFFFFFF, 8, 32'h7FFFFFF0, 4'h0, 1'b1, 1'b0);
    sendBlock(28'h0000001, 17, 32'h4444, 4'b0110, 1'b0, 1'b1);
    sendBlock(28'h0000042, 65535, 32'h55, 4'hF, 1'b0, 1'b0);  // R7 boundary
    sendBlock(28'h0000043, 65536, 32'h66, 4'hF, 1'b0, 1'b0);  // R7 saturation

    stall = 1'b0;
    for (int t = 0; t < 200 && expQ.size() != 0; t++) @(posedge clk);
    if (expQ.size() != 0) check(expQ.size(), 0, "R4 words missing");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule